// File: doc/BRIEF.md
# Two-Wire Indexed Block Register Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit configuration registers for a clock generator. The registers are reached only through indexed block transfers. A bus master first writes an index byte, which sets the register where the transfer starts. Data bytes that follow in the same write are stored in successive registers. To read, the master writes the index, issues a repeated start and re-addresses the slave in the read direction. The slave then returns one byte count, followed by successive registers, until the master declines a byte.

Both bus lines are oversampled by a faster system clock. Each line passes through a two-flop synchronizer and an edge detector. The slave drives the data line only through an open-drain enable. The whole register bank is presented as a flat parallel bus to the clock logic around the block. When the running index passes the last implemented register it wraps to register 0. A begin index at or beyond the register count is reduced modulo the register count.

Top module: `blkreg_slave`

## Requirements
- R1: After reset every register i holds the value (29*i + 5) mod 256, and the open-drain enable is low.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), that is the 7-bit address 0x69 followed by the direction bit. For any other address it leaves the data line released for the rest of that transaction, and no register changes until the next start.
- R3: For each byte the slave receives and accepts (its address, the index and every write data byte), it pulls the data line low through the ninth clock period.
- R4: In a write transaction, the bytes after the index byte are stored in registers M, M+1, M+2 and onward, where M is the begin index. A stop after any complete byte ends the transfer, and the registers written so far keep their new values.
- R5: After a repeated start with 0xD3, the first byte the slave sends is the register count N. The bytes that follow are registers M, M+1 and onward. Each byte is sent most significant bit first.
- R6: When the master does not acknowledge a byte the slave has sent, the slave releases the data line at once. It keeps the line released, even if clocks continue, until the next start.
- R7: The running index wraps from register N-1 back to register 0. A begin index of N or more selects register (index mod N).
- R8: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A repeated start in any state returns the slave to address reception.
- R9: The open-drain enable changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| regs_o | output | NUM_REGS*8 | Register bank, register i at bits [8*i+7:8*i] |

## Verification
The bench builds the slave with NUM_REGS = 6, which is not a power of two. Wrapping at register 5 and reducing random begin indices up to 255 modulo 6 therefore go through a real remainder, not a bit mask. The small bank lets short random bursts run past the end several times, so wrap and count behaviour is covered with only a few thousand bus bits. The address stays at 0x69, so both direction bytes and a rejected address are reached with directed transfers.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_t;

  // Power-on content of register i.
  function automatic logic [7:0] reg_default(input int unsigned i);
    return 8'((i * 29) + 5);
  endfunction

  // Begin index reduced into the implemented range.
  function automatic int unsigned idx_wrap(input logic [7:0] m, input int unsigned n);
    return 32'(m) % n;
  endfunction

  // Successor of a register index, wrapping to zero past the last one.
  function automatic int unsigned idx_next(input int unsigned i, input int unsigned n);
    return ((i + 1) >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/blkreg_sampler.sv
module blkreg_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // [0],[1] form the synchronizer, [2] holds the previous synchronized value
  logic [2:0] scl_sh;
  logic [2:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign scl_s     = scl_sh[1];
  assign sda_s     = sda_sh[1];
  assign scl_rise  = scl_sh[1] & ~scl_sh[2];
  assign scl_fall  = ~scl_sh[1] & scl_sh[2];
  assign start_det = scl_sh[1] & scl_sh[2] & ~sda_sh[1] & sda_sh[2];
  assign stop_det  = scl_sh[1] & scl_sh[2] & sda_sh[1] & ~sda_sh[2];

endmodule

// File: rtl/blkreg_bank.sv
module blkreg_bank
  import blkreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reg_default(g);
      else if (wr_en && (wr_idx == IDX_W'(g))) q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs_flat[i*8 +: 8];
    end
  end

  // The index logic upstream must never point outside the bank
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NUM_REGS));
  assert_rd_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_idx) < NUM_REGS);

endmodule

// File: rtl/blkreg_slave.sv
module blkreg_slave
  import blkreg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int         IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  blkreg_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  phase_t           phase_q;
  logic [3:0]       bitcnt_q;   // 0..8 data bits seen, 9 after the ack bit
  logic [7:0]       shreg_q;
  logic             sda_oe_q;
  logic             rw_q;
  logic             host_ack_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rd_data;

  // Named events used by the datapath and the assertions
  logic active, byte_end, ack_end, addr_hit, tx_stop, wr_en;
  assign active   = phase_q inside {PH_ADDR, PH_INDEX, PH_WDATA, PH_RDATA};
  assign byte_end = active && scl_fall && (bitcnt_q == 4'd8);
  assign ack_end  = active && scl_fall && (bitcnt_q == 4'd9);
  assign addr_hit = (shreg_q[7:1] == DEV_ADDR);
  assign tx_stop  = ack_end && (phase_q == PH_RDATA) && !host_ack_q;
  assign wr_en    = byte_end && (phase_q == PH_WDATA);

  blkreg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (idx_q),
    .wr_data   (shreg_q),
    .rd_idx    (idx_q),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      bitcnt_q   <= 4'd0;
      shreg_q    <= 8'h00;
      sda_oe_q   <= 1'b0;
      rw_q       <= 1'b0;
      host_ack_q <= 1'b0;
      idx_q      <= '0;
    end else if (start_det) begin
      phase_q  <= PH_ADDR;
      bitcnt_q <= 4'd0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= 4'd0;
      sda_oe_q <= 1'b0;
    end else if (active && scl_rise) begin
      if (bitcnt_q < 4'd8) begin
        if (phase_q != PH_RDATA) shreg_q <= {shreg_q[6:0], sda_s};
        bitcnt_q <= bitcnt_q + 4'd1;
      end else if (bitcnt_q == 4'd8) begin
        host_ack_q <= ~sda_s;
        bitcnt_q   <= 4'd9;
      end
    end else if (active && scl_fall) begin
      if (phase_q == PH_RDATA) begin
        if (bitcnt_q >= 4'd1 && bitcnt_q <= 4'd7) begin
          shreg_q  <= {shreg_q[6:0], 1'b0};
          sda_oe_q <= ~shreg_q[6];
        end else if (bitcnt_q == 4'd8) begin
          sda_oe_q <= 1'b0;
        end else if (bitcnt_q == 4'd9) begin
          if (host_ack_q) begin
            shreg_q  <= rd_data;
            sda_oe_q <= ~rd_data[7];
            idx_q    <= IDX_W'(idx_next(32'(idx_q), NUM_REGS));
            bitcnt_q <= 4'd0;
          end else begin
            sda_oe_q <= 1'b0;
            phase_q  <= PH_IGNORE;
          end
        end
      end else if (bitcnt_q == 4'd8) begin
        case (phase_q)
          PH_ADDR: begin
            if (addr_hit) begin
              sda_oe_q <= 1'b1;
              rw_q     <= shreg_q[0];
            end else begin
              phase_q <= PH_IGNORE;
            end
          end
          PH_INDEX: begin
            idx_q    <= IDX_W'(idx_wrap(shreg_q, NUM_REGS));
            sda_oe_q <= 1'b1;
          end
          default: begin  // PH_WDATA: bank stores shreg_q at idx_q this cycle
            idx_q    <= IDX_W'(idx_next(32'(idx_q), NUM_REGS));
            sda_oe_q <= 1'b1;
          end
        endcase
      end else if (bitcnt_q == 4'd9) begin
        bitcnt_q <= 4'd0;
        sda_oe_q <= 1'b0;
        if (phase_q == PH_ADDR) begin
          if (rw_q) begin
            phase_q  <= PH_RDATA;
            shreg_q  <= COUNT_BYTE;
            sda_oe_q <= ~COUNT_BYTE[7];
          end else begin
            phase_q <= PH_INDEX;
          end
        end else if (phase_q == PH_INDEX) begin
          phase_q <= PH_WDATA;
        end
      end
    end
  end

  assign sda_oe_o = sda_oe_q;

  // Ack held low across the whole ninth clock of an accepted received byte
  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q inside {PH_ADDR, PH_INDEX, PH_WDATA}) && bitcnt_q == 4'd9) |-> sda_oe_q);

  // Rejected or finished transactions keep the line released
  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGNORE || phase_q == PH_IDLE) |-> !sda_oe_q);

  assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop |=> (!sda_oe_q && phase_q == PH_IGNORE));

  assert_start_to_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase_q == PH_ADDR && bitcnt_q == 4'd0 && !sda_oe_q));

  assert_count_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && phase_q == PH_ADDR && rw_q) |=> (phase_q == PH_RDATA && shreg_q == COUNT_BYTE));

  assert_sda_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !$past(scl_s));

endmodule

// File: tb/test_blkreg_slave.sv
module test_blkreg_slave;

  localparam int NR = 6;
  localparam int Q  = 8;  // system clocks per quarter bus bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  wire sda_bus = host_sda & ~sda_oe;

  always #4 clk = ~clk;

  blkreg_slave #(.NUM_REGS(NR), .DEV_ADDR(7'h69)) i_blkreg_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  int errors = 0;
  int checks = 0;
  int r9_bad = 0;
  logic [7:0] model [NR];

  function automatic logic [7:0] dflt(input int i);
    return 8'((29 * i + 5) % 256);
  endfunction
  function automatic int wrap(input int m);
    return m % NR;
  endfunction
  function automatic int nxt(input int i);
    return (i == NR - 1) ? 0 : i + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic bus_restart();
    host_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic bus_stop();
    host_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); host_sda = 1'b1; tick(Q);
  endtask
  task automatic send_bit(input logic b);
    host_sda = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask
  task automatic read_bit(output logic b);
    host_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      read_bit(b);
      v = {v[6:0], b};
    end
    send_bit(~give_ack);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++) check(req, 32'(regs[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic write_block(input logic [7:0] m, input int len);
    logic ack;
    int idx;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, ack); check("R2 write address ack", 32'(ack), 1);
    send_byte(m, ack);     check("R3 index ack", 32'(ack), 1);
    idx = wrap(int'(m));
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); check("R3 data ack", 32'(ack), 1);
      model[idx] = d;
      idx = nxt(idx);
    end
    bus_stop();
    check_regs("R4/R7 block write contents");
  endtask

  task automatic read_block(input logic [7:0] m, input int len);
    logic ack;
    logic [7:0] v;
    int idx;
    bus_start();
    send_byte(8'hD2, ack); check("R2 address ack", 32'(ack), 1);
    send_byte(m, ack);     check("R3 index ack", 32'(ack), 1);
    bus_restart();
    send_byte(8'hD3, ack); check("R8 read address ack after restart", 32'(ack), 1);
    recv_byte(v, 1'b1);    check("R5 byte count", 32'(v), NR);
    idx = wrap(int'(m));
    for (int k = 0; k < len; k++) begin
      recv_byte(v, k != len - 1);
      check("R5/R7 read data", 32'(v), 32'(model[idx]));
      idx = nxt(idx);
    end
    check("R6 released after nack", 32'(sda_oe), 0);
    bus_stop();
  endtask

  // R9 monitor: the enable must move only while the clock line is low
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) r9_bad++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic b;
    logic [7:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset contents and released line
    check_regs("R1 reset defaults");
    check("R1 enable low after reset", 32'(sda_oe), 0);

    // R4/R7: write across the end of the bank, then read back wrapping
    write_block(8'd4, 5);
    read_block(8'd4, 8);
    // R7: begin index far above the bank size
    write_block(8'd200, 2);
    read_block(8'd251, 3);

    // R2: foreign address is not acknowledged and its data is dropped
    bus_start();
    send_byte(8'hA4, ack); check("R2 foreign address nack", 32'(ack), 0);
    send_byte(8'd1, ack);  check("R2 ignored index nack", 32'(ack), 0);
    send_byte(8'h5A, ack); check("R2 ignored data nack", 32'(ack), 0);
    bus_stop();
    check_regs("R2 registers untouched");
    bus_start();
    send_byte(8'hD0, ack); check("R2 neighbour address nack", 32'(ack), 0);
    bus_stop();

    // R6: after the master declines, further clocks see a released line
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'd0, ack);
    bus_restart();
    send_byte(8'hD3, ack);
    recv_byte(v, 1'b1); check("R5 count directed", 32'(v), NR);
    recv_byte(v, 1'b0); check("R5 first register directed", 32'(v), 32'(model[0]));
    for (int i = 0; i < 9; i++) begin
      read_bit(b);
      check("R6 line stays released", 32'(b), 1);
    end
    bus_stop();

    // R8: repeated start in the middle of a write restarts addressing
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'd1, ack);
    send_byte(8'h11, ack); model[1] = 8'h11;
    bus_restart();
    send_byte(8'hD2, ack); check("R8 address after mid-write restart", 32'(ack), 1);
    send_byte(8'd3, ack);
    send_byte(8'h33, ack); model[3] = 8'h33;
    send_byte(8'h44, ack); model[4] = 8'h44;
    bus_stop();
    check_regs("R8 restart write contents");

    // Random mix of block writes and reads
    for (int t = 0; t < 10; t++) begin
      write_block(8'($urandom), 1 + int'($urandom % 8));
      read_block(8'($urandom), 1 + int'($urandom % 8));
    end

    check("R9 enable changes with clock line high", 32'(r9_bad), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule